// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Peripheral Override

This block is one parameterized I/O port (eight pins by default). Each pin holds a direction bit and an output-data bit, written by the CPU through per-port write strobes. From these bits, two shared controls (sleep and a global pull-up disable) and a set of per-pin override enable/value pairs driven by on-chip peripherals, the block resolves four pad controls for every pin: output enable, output value, pull-up request and digital input enable.

Each pad control can be taken over by a peripheral on its own, without touching the others. A toggle override lets a peripheral flip the output-data bit. Peripherals receive the pad input gated by the input enable, ahead of any synchronizer. The CPU reads the pin state through a two-stage synchronizer. One pin can be made to behave as an open-drain line by driving its direction override from the peripheral and forcing its value override to 0.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction and output-data registers are all 0. With no override active, every pin has pad_oe_o=0, pad_out_o=0 and pad_pu_o=0, and a pin read returns 0.
- R2: Where pu_ovr_en_i is 0, pad_pu_o is 1 only when the direction bit is 0, the output-data bit is 1 and pu_dis_i is 0. Where pu_ovr_en_i is 1, pad_pu_o equals pu_ovr_val_i.
- R3: pad_oe_o equals dir_ovr_val_i where dir_ovr_en_i is 1, and the direction register bit otherwise.
- R4: Where pad_oe_o is 1, pad_out_o equals val_ovr_val_i if val_ovr_en_i is 1, and the output-data bit otherwise. Where pad_oe_o is 0, pad_out_o is 0.
- R5: in_en_o equals ie_ovr_val_i where ie_ovr_en_i is 1, and ~sleep_i otherwise. periph_in_o equals pad_in_i AND in_en_o in the same cycle, without a register.
- R6: The pin read path samples pad_in_i AND in_en_o through two flops. A pin read returns the value present before the clock edge two edges earlier, so a disabled input reads 0.
- R7: dir_wr_i or out_wr_i loads wdata_i into the direction or output-data register at the next clock edge. A read strobe returns that register's contents in the same cycle.
- R8: pin_wr_i inverts at the next clock edge each output-data bit whose wdata_i bit is 1. Bits with wdata_i 0 keep their value.
- R9: A pin with tgl_ovr_en_i set has its output-data bit inverted at every clock edge while the enable is set. In the same cycle it combines with a pin_wr_i toggle by XOR, so two toggles cancel.
- R10: rdata_o is the bitwise OR of the direction register (dir_rd_i), the output-data register (out_rd_i) and the synchronized pins (pin_rd_i), each included only when its strobe is high. With no strobe high, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | WIDTH | CPU write data |
| dir_wr_i | input | 1 | Write strobe for the direction register |
| out_wr_i | input | 1 | Write strobe for the output-data register |
| pin_wr_i | input | 1 | Write strobe for the pin register (toggles output data) |
| dir_rd_i | input | 1 | Read strobe for the direction register |
| out_rd_i | input | 1 | Read strobe for the output-data register |
| pin_rd_i | input | 1 | Read strobe for the synchronized pins |
| rdata_o | output | WIDTH | CPU read data |
| sleep_i | input | 1 | Sleep control, disables inputs unless overridden |
| pu_dis_i | input | 1 | Global pull-up disable |
| pu_ovr_en_i | input | WIDTH | Pull-up override enable per pin |
| pu_ovr_val_i | input | WIDTH | Pull-up override value per pin |
| dir_ovr_en_i | input | WIDTH | Direction override enable per pin |
| dir_ovr_val_i | input | WIDTH | Direction override value per pin |
| val_ovr_en_i | input | WIDTH | Output-value override enable per pin |
| val_ovr_val_i | input | WIDTH | Output-value override value per pin |
| tgl_ovr_en_i | input | WIDTH | Output-data toggle request per pin |
| ie_ovr_en_i | input | WIDTH | Input-enable override enable per pin |
| ie_ovr_val_i | input | WIDTH | Input-enable override value per pin |
| pad_in_i | input | WIDTH | Pad input level |
| pad_oe_o | output | WIDTH | Pad output driver enable |
| pad_out_o | output | WIDTH | Pad output value |
| pad_pu_o | output | WIDTH | Pad pull-up request |
| in_en_o | output | WIDTH | Resolved digital input enable |
| periph_in_o | output | WIDTH | Gated pad input to peripherals, unsynchronized |

## Verification
Two updates can reach the output-data register at the same clock edge: a CPU pin-register write and a peripheral toggle override. The bench drives both in one cycle with overlapping and disjoint masks. It then reads the register back and compares it with the old value XORed with both masks, so a bit toggled by both sources must come back unchanged. It also drives a direction override and a value override at the same time to check the open-drain pattern, where the pad is driven only low.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic val_en;
    logic val_val;
    logic ie_en;
    logic ie_val;
  } pin_ovr_t;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             dir_wr_i,
  input  logic             out_wr_i,
  input  logic             pin_wr_i,
  input  logic [WIDTH-1:0] tgl_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] port_o
);
  logic [WIDTH-1:0] port_base, flip_mask;

  assign port_base = out_wr_i ? wdata_i : port_o;
  // cpu toggle and peripheral toggle cancel when both hit a bit
  assign flip_mask = (pin_wr_i ? wdata_i : '0) ^ tgl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      port_o <= '0;
    end else begin
      if (dir_wr_i) dir_o <= wdata_i;
      port_o <= port_base ^ flip_mask;
    end
  end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_ovr_pkg::*;
(
  input  pin_ovr_t ovr_i,
  input  logic     dir_i,
  input  logic     port_i,
  input  logic     sleep_i,
  input  logic     pu_dis_i,
  output logic     oe_o,
  output logic     out_o,
  output logic     pu_o,
  output logic     ie_o
);
  logic pu_reg;

  assign pu_reg = ~dir_i & port_i & ~pu_dis_i;
  assign pu_o   = ovr_i.pu_en  ? ovr_i.pu_val  : pu_reg;
  assign oe_o   = ovr_i.dir_en ? ovr_i.dir_val : dir_i;
  assign out_o  = oe_o & (ovr_i.val_en ? ovr_i.val_val : port_i);
  assign ie_o   = ovr_i.ie_en  ? ovr_i.ie_val  : ~sleep_i;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             dir_wr_i,
  input  logic             out_wr_i,
  input  logic             pin_wr_i,
  input  logic             dir_rd_i,
  input  logic             out_rd_i,
  input  logic             pin_rd_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             sleep_i,
  input  logic             pu_dis_i,
  input  logic [WIDTH-1:0] pu_ovr_en_i,
  input  logic [WIDTH-1:0] pu_ovr_val_i,
  input  logic [WIDTH-1:0] dir_ovr_en_i,
  input  logic [WIDTH-1:0] dir_ovr_val_i,
  input  logic [WIDTH-1:0] val_ovr_en_i,
  input  logic [WIDTH-1:0] val_ovr_val_i,
  input  logic [WIDTH-1:0] tgl_ovr_en_i,
  input  logic [WIDTH-1:0] ie_ovr_en_i,
  input  logic [WIDTH-1:0] ie_ovr_val_i,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o,
  output logic [WIDTH-1:0] in_en_o,
  output logic [WIDTH-1:0] periph_in_o
);
  logic [WIDTH-1:0] dir_q, port_q, pin_sync;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (wdata_i),
    .dir_wr_i (dir_wr_i),
    .out_wr_i (out_wr_i),
    .pin_wr_i (pin_wr_i),
    .tgl_i    (tgl_ovr_en_i),
    .dir_o    (dir_q),
    .port_o   (port_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_ovr_t ovr;
    assign ovr = '{pu_en:   pu_ovr_en_i[i],  pu_val:  pu_ovr_val_i[i],
                   dir_en:  dir_ovr_en_i[i], dir_val: dir_ovr_val_i[i],
                   val_en:  val_ovr_en_i[i], val_val: val_ovr_val_i[i],
                   ie_en:   ie_ovr_en_i[i],  ie_val:  ie_ovr_val_i[i]};

    gpio_pin_ctl u_ctl (
      .ovr_i    (ovr),
      .dir_i    (dir_q[i]),
      .port_i   (port_q[i]),
      .sleep_i  (sleep_i),
      .pu_dis_i (pu_dis_i),
      .oe_o     (pad_oe_o[i]),
      .out_o    (pad_out_o[i]),
      .pu_o     (pad_pu_o[i]),
      .ie_o     (in_en_o[i])
    );
  end

  // disabled inputs read as 0 so a floating pad stays quiet
  assign periph_in_o = pad_in_i & in_en_o;

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (periph_in_o),
    .q_o    (pin_sync)
  );

  assign rdata_o = ({WIDTH{dir_rd_i}} & dir_q)
                 | ({WIDTH{out_rd_i}} & port_q)
                 | ({WIDTH{pin_rd_i}} & pin_sync);
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] wdata_i,
  input logic             dir_wr_i,
  input logic             dir_rd_i,
  input logic             out_rd_i,
  input logic             pin_rd_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             sleep_i,
  input logic [WIDTH-1:0] pu_ovr_en_i,
  input logic [WIDTH-1:0] pu_ovr_val_i,
  input logic [WIDTH-1:0] dir_ovr_en_i,
  input logic [WIDTH-1:0] ie_ovr_en_i,
  input logic [WIDTH-1:0] pad_in_i,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_pu_o,
  input logic [WIDTH-1:0] in_en_o,
  input logic [WIDTH-1:0] periph_in_o
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       age <= '0;
    else if (age != 2) age <= age + 2'd1;
  end

  // R2
  pu_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_pu_o ^ pu_ovr_val_i) & pu_ovr_en_i) == '0);

  // R2
  pu_not_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o & ~pu_ovr_en_i & ~dir_ovr_en_i) == '0);

  // R7
  dir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 0 && $past(dir_wr_i)) |-> ((pad_oe_o ^ $past(wdata_i)) & ~dir_ovr_en_i) == '0);

  // R4
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);

  // R5
  sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (periph_in_o & ~ie_ovr_en_i) == '0);

  // R5
  periph_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_in_o & ~(pad_in_i & in_en_o)) == '0);

  // R6
  pin_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2 && pin_rd_i && !dir_rd_i && !out_rd_i)
      |-> rdata_o == $past(pad_in_i & in_en_o, 2));

  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rd_i && !out_rd_i && !pin_rd_i) |-> rdata_o == '0);
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_port_ovr_bench.sv
module gpio_port_ovr_bench;
  localparam int W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic dir_wr_i = 0, out_wr_i = 0, pin_wr_i = 0;
  logic dir_rd_i = 0, out_rd_i = 0, pin_rd_i = 0;
  logic [W-1:0] rdata_o;
  logic sleep_i = 0, pu_dis_i = 0;
  logic [W-1:0] pu_ovr_en_i = '0, pu_ovr_val_i = '0;
  logic [W-1:0] dir_ovr_en_i = '0, dir_ovr_val_i = '0;
  logic [W-1:0] val_ovr_en_i = '0, val_ovr_val_i = '0;
  logic [W-1:0] tgl_ovr_en_i = '0;
  logic [W-1:0] ie_ovr_en_i = '0, ie_ovr_val_i = '0;
  logic [W-1:0] pad_in_i = '0;
  logic [W-1:0] pad_oe_o, pad_out_o, pad_pu_o, in_en_o, periph_in_o;

  int n_chk = 0, n_err = 0;
  logic [W-1:0] m_dir, m_port;

  always #4 clk_i = ~clk_i;

  gpio_port_ovr #(.WIDTH(W)) u_gpio_port_ovr (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd(input int sel, output logic [W-1:0] v);
    dir_rd_i = (sel == 0); out_rd_i = (sel == 1); pin_rd_i = (sel == 2);
    #1 v = rdata_o;
    dir_rd_i = 0; out_rd_i = 0; pin_rd_i = 0;
  endtask

  task automatic wr(input int sel, input logic [W-1:0] d);
    wdata_i = d;
    dir_wr_i = (sel == 0); out_wr_i = (sel == 1); pin_wr_i = (sel == 2);
    tick();
    dir_wr_i = 0; out_wr_i = 0; pin_wr_i = 0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(0, v); chk("R1 dir", v, '0);
    rd(1, v); chk("R1 port", v, '0);
    rd(2, v); chk("R1 pin", v, '0);
    chk("R1 oe", pad_oe_o, '0);
    chk("R1 out", pad_out_o, '0);
    chk("R1 pu", pad_pu_o, '0);
  endtask

  task automatic t_regs();
    logic [W-1:0] v;
    m_dir = 8'hA5; m_port = 8'h3C;
    wr(0, m_dir); wr(1, m_port);
    rd(0, v); chk("R7 dir readback", v, m_dir);
    rd(1, v); chk("R7 port readback", v, m_port);
    #1;
    chk("R3 oe from dir", pad_oe_o, m_dir);
    chk("R4 out from port", pad_out_o, m_dir & m_port);
    chk("R2 pull-up", pad_pu_o, ~m_dir & m_port);
    pu_dis_i = 1; #1;
    chk("R2 global disable", pad_pu_o, '0);
    pu_dis_i = 0;
  endtask

  task automatic t_override();
    dir_ovr_en_i = 8'h0F; dir_ovr_val_i = 8'h0A;
    #1 chk("R3 dir override", pad_oe_o, 8'hAA);
    chk("R4 out partial", pad_out_o, 8'hAA & m_port);
    val_ovr_en_i = 8'hFF; val_ovr_val_i = 8'hF0;
    #1 chk("R4 value override", pad_out_o, 8'hA0);
    pu_ovr_en_i = 8'hFF; pu_ovr_val_i = 8'h81;
    #1 chk("R2 pull-up override", pad_pu_o, 8'h81);
    dir_ovr_en_i = '0; val_ovr_en_i = '0; pu_ovr_en_i = '0;
  endtask

  task automatic t_input();
    logic [W-1:0] v;
    pad_in_i = 8'h96;
    #1 chk("R5 periph input", periph_in_o, 8'h96);
    tick();
    rd(2, v); chk("R6 one edge still old", v, 8'h00);
    tick();
    rd(2, v); chk("R6 two edges", v, 8'h96);
    sleep_i = 1;
    #1 chk("R5 sleep gate", periph_in_o, '0);
    ie_ovr_en_i = 8'h0F; ie_ovr_val_i = 8'h03;
    #1 chk("R5 ie override", in_en_o, 8'h03);
    chk("R5 periph gated", periph_in_o, 8'h02);
    tick(); tick();
    rd(2, v); chk("R6 disabled reads 0", v, 8'h02);
    sleep_i = 0; ie_ovr_en_i = '0; pad_in_i = '0;
  endtask

  task automatic t_toggle();
    logic [W-1:0] v;
    wr(2, 8'h0F); m_port ^= 8'h0F;
    rd(1, v); chk("R8 pin write toggle", v, m_port);
    tgl_ovr_en_i = 8'h81; tick(); tgl_ovr_en_i = '0; m_port ^= 8'h81;
    rd(1, v); chk("R9 toggle override", v, m_port);
    tgl_ovr_en_i = 8'h06; wr(2, 8'h03); tgl_ovr_en_i = '0;
    m_port ^= 8'h05;
    rd(1, v); chk("R9 same-cycle xor", v, m_port);
  endtask

  task automatic t_rdata();
    #1 chk("R10 idle zero", rdata_o, '0);
    dir_rd_i = 1; out_rd_i = 1;
    #1 chk("R10 or combine", rdata_o, m_dir | m_port);
    dir_rd_i = 0; out_rd_i = 0;
  endtask

  task automatic t_open_drain();
    wr(0, 8'h01); wr(1, 8'h01);
    dir_ovr_en_i = 8'h01; val_ovr_en_i = 8'h01; val_ovr_val_i = '0;
    dir_ovr_val_i = 8'h00; // dir=1, port=1, no hold -> released
    #1 chk("R3 open-drain released", pad_oe_o, 8'h00);
    dir_ovr_val_i = 8'h01; // hold request -> drive low
    #1 chk("R3 open-drain hold", pad_oe_o, 8'h01);
    chk("R4 open-drain low", pad_out_o, 8'h00);
    dir_ovr_en_i = '0; val_ovr_en_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    tick();
    t_regs();
    t_override();
    t_input();
    t_toggle();
    t_rdata();
    t_open_drain();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule